// File: doc/BRIEF.md
# Variable-Length Instruction Predecoder

This block sits between an instruction fetch stage and the decode stage of a small core. It accepts 16-bit instruction halfwords one at a time through a valid/ready handshake. Bit 0 of each first halfword tells it whether the instruction is 16 or 32 bits long. For a long instruction it keeps the first halfword until the second one arrives. Once an instruction is complete, it emits one decoded record through a valid/ready output register.

The record gives the operand form, the opcode and both 4-bit source fields, the destination register resolved for that form, the immediate already widened to the datapath width, the 7-bit write-back condition and a length flag. The length flag lets the program counter advance by 2 or 4 bytes.

A two-state machine follows the halfword stream:
- `ST_FIRST_HALF` expects the first halfword of an instruction.
- `ST_SECOND_HALF` holds the first half of a long instruction.
- *take_short* (ST_FIRST_HALF → ST_FIRST_HALF) accepts a halfword with bit 0 clear and emits a record.
- *open_long* (ST_FIRST_HALF → ST_SECOND_HALF) accepts a halfword with bit 0 set and stores it.
- *close_long* (ST_SECOND_HALF → ST_FIRST_HALF) accepts the upper halfword and emits a record.
- *flush* (any state → ST_FIRST_HALF) discards a stored half.

Top module: `insn_predecoder`

## Requirements
- R1: While reset is low and on the first cycle after reset, `out_valid` is 0, `in_ready` is 1, and the next accepted halfword is treated as a first halfword.
- R2: A first halfword with bit 0 clear is a complete instruction. Its record appears with `out_long`=0 in the cycle after it is accepted. `out_long` is 1 exactly for forms 2, 3 and 4.
- R3: The fields of the first halfword are decoded as follows:
  - bits 15:12 appear on `out_src_a` and bits 11:8 on `out_src_b`;
  - bits 7:2 appear on `out_opcode`;
  - in a short instruction the destination is bits 11:8;
  - bit 1 of a short instruction selects form 0 (register; immediate is 0) or form 1 (the 4-bit value in bits 15:12 sign-extended).
- R4: A first halfword with bit 0 set produces no record. The next accepted halfword supplies bits 31:16, and the record (with `out_long`=1) appears in the cycle after that halfword is accepted. Every record follows an accepted halfword.
- R5: In a long instruction with bit 1 clear (form 2), the destination is bits 15:12 and the immediate is bits 31:16. That immediate is sign-extended when `LONG_IMM_SIGNED`=1 and zero-extended otherwise. The condition is 0.
- R6: In a long instruction with bit 1 set, the destination is bits 31:28 and the condition is bits 26:20, passed through unchanged. Bit 27 selects form 3 (register; immediate is 0) or form 4 (expanded immediate). Bits 19:16 are ignored. Forms 0, 1 and 2 report condition 0 ("always").
- R7: In form 4, the 4-bit code in bits 15:12 expands as follows:
  - codes 8..15 give -16, -14 … -2;
  - codes 4..7 give 8, 10, 12, 14;
  - codes 0..3 give 16, 18, 20, 22.
  The result is sign-extended to `DATA_W`.
- R8: `in_ready` is 1 only when `flush` is low and the output register is empty or being drained. While `out_valid` is 1 and `out_ready` is 0, the record stays unchanged and no halfword is taken. No halfword is lost or duplicated.
- R9: While `flush` is high, no halfword is accepted and a stored first half is discarded. The next accepted halfword is a first halfword.
- R10: While a stored first half waits for its second halfword, `out_valid` stays 0 once any earlier record has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard any partial instruction |
| in_valid | input | 1 | Halfword offered |
| in_ready | output | 1 | Halfword taken this cycle when in_valid is 1 |
| in_half | input | 16 | Instruction halfword |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_form | output | 3 | 0 short reg, 1 short imm, 2 long imm, 3 ext reg, 4 ext imm |
| out_long | output | 1 | 1 for a 32-bit instruction |
| out_opcode | output | 6 | Opcode |
| out_src_a | output | 4 | Bits 15:12 (register or 4-bit immediate code) |
| out_src_b | output | 4 | Bits 11:8 |
| out_dst | output | 4 | Resolved destination register |
| out_imm | output | DATA_W | Widened immediate |
| out_cond | output | 7 | Write-back condition |

## Verification
The bench builds the block with `DATA_W`=24 and `LONG_IMM_SIGNED`=1, so sign extension of both immediate kinds is visible above bit 15. It sweeps every short encoding (all 32768 halfwords with bit 0 clear). It also sweeps every extended combination of immediate code, form bit and 7-bit condition under a repeating back-pressure pattern. Long-immediate instructions with edge-value upper halfwords, a forced stall, a delayed second halfword and a flush in mid-instruction reach the handshake and discard paths.

// File: rtl/predec_pkg.sv
package predec_pkg;

    localparam int HALF_W = 16;
    localparam int REG_W  = 4;
    localparam int OPC_W  = 6;
    localparam int COND_W = 7;

    // first halfword layout
    localparam int LEN_BIT  = 0;
    localparam int SEL_BIT  = 1;
    localparam int OPC_LSB  = 2;
    localparam int SRCB_LSB = 8;
    localparam int SRCA_LSB = 12;

    // upper halfword layout of extended forms (positions inside the halfword)
    localparam int XCOND_LSB = 4;
    localparam int XIMM_BIT  = 11;
    localparam int XDST_LSB  = 12;

    typedef enum logic [2:0] {
        FORM_SHORT_REG = 3'd0,
        FORM_SHORT_IMM = 3'd1,
        FORM_LONG_IMM  = 3'd2,
        FORM_EXT_REG   = 3'd3,
        FORM_EXT_IMM   = 3'd4
    } form_e;

    typedef enum logic {
        ST_FIRST_HALF  = 1'b0,
        ST_SECOND_HALF = 1'b1
    } seq_state_e;

    typedef struct packed {
        form_e              form;
        logic               is_long;
        logic [OPC_W-1:0]   opcode;
        logic [REG_W-1:0]   src_a;
        logic [REG_W-1:0]   src_b;
        logic [REG_W-1:0]   dst;
        logic [COND_W-1:0]  cond;
    } rec_hdr_t;

endpackage

// File: rtl/predec_imm4.sv
module predec_imm4
    import predec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  code,
    output logic [DATA_W-1:0] value
);

    localparam int NARROW_W = REG_W + 2;

    logic [NARROW_W-1:0] narrow;

    // negative codes double, 4..7 double, 0..3 double and add sixteen
    always_comb begin
        unique case (code[3:2])
            2'b00:   narrow = {3'b010, code[1:0], 1'b0};
            2'b01:   narrow = {1'b0, code, 1'b0};
            default: narrow = {code[3], code, 1'b0};
        endcase
    end

    assign value = {{(DATA_W-NARROW_W){narrow[NARROW_W-1]}}, narrow};

endmodule

// File: rtl/predec_fields.sv
module predec_fields
    import predec_pkg::*;
#(
    parameter int DATA_W          = 32,
    parameter bit LONG_IMM_SIGNED = 1'b0
) (
    input  logic [HALF_W-1:0] lo,
    input  logic [HALF_W-1:0] hi,
    input  logic              is_long,
    output rec_hdr_t          hdr,
    output logic [DATA_W-1:0] imm
);

    logic [REG_W-1:0]  si4;
    logic [DATA_W-1:0] short_imm;
    logic [DATA_W-1:0] long_imm;
    logic [DATA_W-1:0] table_imm;

    assign si4       = lo[SRCA_LSB +: REG_W];
    assign short_imm = {{(DATA_W-REG_W){si4[REG_W-1]}}, si4};

    generate
        if (LONG_IMM_SIGNED) begin : g_long_sext
            assign long_imm = {{(DATA_W-HALF_W){hi[HALF_W-1]}}, hi};
        end else begin : g_long_zext
            assign long_imm = {{(DATA_W-HALF_W){1'b0}}, hi};
        end
    endgenerate

    predec_imm4 #(.DATA_W(DATA_W)) u_imm4 (
        .code  (si4),
        .value (table_imm)
    );

    always_comb begin
        hdr.is_long = is_long;
        hdr.opcode  = lo[OPC_LSB +: OPC_W];
        hdr.src_a   = si4;
        hdr.src_b   = lo[SRCB_LSB +: REG_W];
        hdr.dst     = lo[SRCB_LSB +: REG_W];
        hdr.cond    = '0;
        hdr.form    = FORM_SHORT_REG;
        imm         = '0;
        if (!is_long) begin
            if (lo[SEL_BIT]) begin
                hdr.form = FORM_SHORT_IMM;
                imm      = short_imm;
            end
        end else if (!lo[SEL_BIT]) begin
            hdr.form = FORM_LONG_IMM;
            hdr.dst  = si4;
            imm      = long_imm;
        end else begin
            hdr.dst  = hi[XDST_LSB +: REG_W];
            hdr.cond = hi[XCOND_LSB +: COND_W];
            if (hi[XIMM_BIT]) begin
                hdr.form = FORM_EXT_IMM;
                imm      = table_imm;
            end else begin
                hdr.form = FORM_EXT_REG;
            end
        end
    end

endmodule

// File: rtl/predec_ctrl.sv
module predec_ctrl
    import predec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic in_valid,
    input  logic in_lsb,
    input  logic out_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic grab_lo,
    output logic emit,
    output logic emit_long
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       fire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FIRST_HALF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        in_ready  = !flush && (!out_valid || out_ready);
        fire      = in_valid && in_ready;
        grab_lo   = 1'b0;
        emit      = 1'b0;
        emit_long = 1'b0;
        state_d   = state_q;
        if (flush) begin
            state_d = ST_FIRST_HALF;
        end else begin
            unique case (state_q)
                ST_FIRST_HALF: begin
                    if (fire) begin
                        if (in_lsb) begin
                            grab_lo = 1'b1;
                            state_d = ST_SECOND_HALF;
                        end else begin
                            emit = 1'b1;
                        end
                    end
                end
                ST_SECOND_HALF: begin
                    if (fire) begin
                        emit      = 1'b1;
                        emit_long = 1'b1;
                        state_d   = ST_FIRST_HALF;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/insn_predecoder.sv
module insn_predecoder
    import predec_pkg::*;
#(
    parameter int DATA_W          = 32,
    parameter bit LONG_IMM_SIGNED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_half,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_form,
    output logic              out_long,
    output logic [5:0]        out_opcode,
    output logic [3:0]        out_src_a,
    output logic [3:0]        out_src_b,
    output logic [3:0]        out_dst,
    output logic [DATA_W-1:0] out_imm,
    output logic [6:0]        out_cond
);

    logic              grab_lo;
    logic              emit;
    logic              emit_long;
    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] dec_lo;
    logic [HALF_W-1:0] dec_hi;
    rec_hdr_t          dec_hdr;
    logic [DATA_W-1:0] dec_imm;
    rec_hdr_t          rec_q;
    logic [DATA_W-1:0] imm_q;
    logic              valid_q;

    predec_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .in_valid  (in_valid),
        .in_lsb    (in_half[LEN_BIT]),
        .out_valid (valid_q),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .grab_lo   (grab_lo),
        .emit      (emit),
        .emit_long (emit_long)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (grab_lo) begin
            lo_q <= in_half;
        end
    end

    assign dec_lo = emit_long ? lo_q : in_half;
    assign dec_hi = emit_long ? in_half : '0;

    predec_fields #(
        .DATA_W          (DATA_W),
        .LONG_IMM_SIGNED (LONG_IMM_SIGNED)
    ) u_fields (
        .lo      (dec_lo),
        .hi      (dec_hi),
        .is_long (emit_long),
        .hdr     (dec_hdr),
        .imm     (dec_imm)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            rec_q   <= '0;
            imm_q   <= '0;
        end else if (emit) begin
            valid_q <= 1'b1;
            rec_q   <= dec_hdr;
            imm_q   <= dec_imm;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign out_valid  = valid_q;
    assign out_form   = rec_q.form;
    assign out_long   = rec_q.is_long;
    assign out_opcode = rec_q.opcode;
    assign out_src_a  = rec_q.src_a;
    assign out_src_b  = rec_q.src_b;
    assign out_dst    = rec_q.dst;
    assign out_imm    = imm_q;
    assign out_cond   = rec_q.cond;

endmodule

module insn_predecoder_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [2:0]        out_form,
    input logic              out_long,
    input logic [5:0]        out_opcode,
    input logic [3:0]        out_src_a,
    input logic [3:0]        out_src_b,
    input logic [3:0]        out_dst,
    input logic [DATA_W-1:0] out_imm,
    input logic [6:0]        out_cond
);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_form) && $stable(out_long)
            && $stable(out_opcode) && $stable(out_src_a) && $stable(out_src_b)
            && $stable(out_dst) && $stable(out_imm) && $stable(out_cond)));

    p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_flush_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    p_new_rec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    p_len_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_long == (out_form >= 3'd2)) && (out_form <= 3'd4));

    p_short_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_long) |-> (out_dst == out_src_b));

    p_reg_imm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_form == 3'd0 || out_form == 3'd3)) |-> (out_imm == '0));

    p_long_imm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_form == 3'd2) |-> (out_dst == out_src_a));

    p_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_form < 3'd3) |-> (out_cond == 7'd0));

    p_table_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_form == 3'd4) |-> (!out_imm[0] && out_imm != '0));

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_opcode_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_opcode));

endmodule

bind insn_predecoder insn_predecoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_form   (out_form),
    .out_long   (out_long),
    .out_opcode (out_opcode),
    .out_src_a  (out_src_a),
    .out_src_b  (out_src_b),
    .out_dst    (out_dst),
    .out_imm    (out_imm),
    .out_cond   (out_cond)
);

// File: tb/insn_predecoder_tb.sv
`timescale 1ns/1ps
module insn_predecoder_tb;

    localparam int TW    = 24;
    localparam int REC_W = 3 + 1 + 6 + 4 + 4 + 4 + TW + 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   in_half = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [2:0]    out_form;
    logic          out_long;
    logic [5:0]    out_opcode;
    logic [3:0]    out_src_a;
    logic [3:0]    out_src_b;
    logic [3:0]    out_dst;
    logic [TW-1:0] out_imm;
    logic [6:0]    out_cond;

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [REC_W-1:0] exp_q[$];

    always #4 clk = ~clk;

    insn_predecoder #(.DATA_W(TW), .LONG_IMM_SIGNED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_ready(in_ready), .in_half(in_half), .out_valid(out_valid),
        .out_ready(out_ready), .out_form(out_form), .out_long(out_long),
        .out_opcode(out_opcode), .out_src_a(out_src_a), .out_src_b(out_src_b),
        .out_dst(out_dst), .out_imm(out_imm), .out_cond(out_cond)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected record from the requirements
    function automatic logic [REC_W-1:0] model(input logic [15:0] lo, input logic [15:0] hi, input bit lng);
        logic [2:0]    f;
        logic [3:0]    d;
        logic [TW-1:0] im;
        logic [6:0]    c;
        int            v;
        int            code;
        code = int'(lo[15:12]);
        d = lo[11:8];
        im = '0;
        c = '0;
        if (!lng) begin
            f = lo[1] ? 3'd1 : 3'd0;
            if (lo[1]) begin
                v = (code >= 8) ? code - 16 : code;
                im = v[TW-1:0];
            end
        end else if (!lo[1]) begin
            f = 3'd2;
            d = lo[15:12];
            v = hi[15] ? int'(hi) - 65536 : int'(hi);
            im = v[TW-1:0];
        end else begin
            d = hi[15:12];
            c = hi[10:4];
            f = hi[11] ? 3'd4 : 3'd3;
            if (hi[11]) begin
                if (code >= 8)      v = -16 + 2 * (code - 8);
                else if (code >= 4) v = 8 + 2 * (code - 4);
                else                v = 16 + 2 * code;
                im = v[TW-1:0];
            end
        end
        return {f, lng, lo[7:2], lo[15:12], lo[11:8], d, im, c};
    endfunction

    // monitor: compare each consumed record at the falling edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected record", 32'(out_opcode), 32'hFFFF);
            end else begin
                logic [REC_W-1:0] e;
                e = exp_q.pop_front();
                chk(out_form == e[REC_W-1 -: 3], "R2/R3/R5/R6 form", 32'(out_form), 32'(e[REC_W-1 -: 3]));
                chk(out_long == e[REC_W-4], "R2/R4 length", 32'(out_long), 32'(e[REC_W-4]));
                chk(out_opcode == e[REC_W-5 -: 6], "R3 opcode", 32'(out_opcode), 32'(e[REC_W-5 -: 6]));
                chk({out_src_a, out_src_b} == e[REC_W-11 -: 8], "R3 sources",
                    32'({out_src_a, out_src_b}), 32'(e[REC_W-11 -: 8]));
                chk(out_dst == e[REC_W-19 -: 4], "R3/R5/R6 destination", 32'(out_dst), 32'(e[REC_W-19 -: 4]));
                chk(out_imm == e[TW+6:7], "R3/R5/R7 immediate", 32'(out_imm), 32'(e[TW+6:7]));
                chk(out_cond == e[6:0], "R6 condition", 32'(out_cond), 32'(e[6:0]));
            end
        end
    end

    // output ready pattern: 0 always ready, 1 every third cycle blocked, 2 held low
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            case (ready_mode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 3) != 0;
                default: out_ready = 1'b0;
            endcase
        end
    end

    task automatic push(input logic [15:0] hw);
        bit acc;
        acc = 1'b0;
        in_half = hw;
        in_valid = 1'b1;
        while (!acc) begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic send_short(input logic [15:0] lo);
        exp_q.push_back(model(lo, 16'h0, 1'b0));
        push(lo);
    endtask

    task automatic send_long(input logic [15:0] lo, input logic [15:0] hi);
        exp_q.push_back(model(lo, hi, 1'b1));
        push(lo);
        push(hi);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'h0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'h0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'h1);
        @(posedge clk);
        #1;

        // R8: stall holds the record and blocks input
        ready_mode = 2;
        idle(1);
        send_short(16'h4762);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R8 record held", 32'(out_valid), 32'h1);
            chk(in_ready == 1'b0, "R8 input blocked", 32'(in_ready), 32'h0);
            chk(out_opcode == 6'h18, "R8 record stable", 32'(out_opcode), 32'h18);
            @(posedge clk);
            #1;
        end
        ready_mode = 0;
        idle(3);

        // R10: stored first half waits, no record
        exp_q.push_back(model(16'h5A11, 16'h8421, 1'b1));
        push(16'h5A11);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R10 no record while waiting", 32'(out_valid), 32'h0);
            @(posedge clk);
            #1;
        end
        push(16'h8421);
        idle(2);

        // R9: flush discards a stored first half
        in_half = 16'h3C03;
        push(16'h3C03);
        flush = 1'b1;
        in_valid = 1'b1;
        in_half = 16'hFFFE;
        @(negedge clk);
        chk(in_ready == 1'b0, "R9 no accept during flush", 32'(in_ready), 32'h0);
        @(posedge clk);
        #1;
        flush = 1'b0;
        in_valid = 1'b0;
        send_short(16'h9236);
        idle(2);
        @(negedge clk);
        chk(exp_q.size() == 0, "R9 flushed half gone", 32'(exp_q.size()), 32'h0);
        @(posedge clk);
        #1;

        // R2/R3: every short encoding
        for (int i = 0; i < 32768; i++) begin
            send_short({i[14:0], 1'b0});
        end

        // R5: long immediate with edge values
        for (int s = 0; s < 16; s++) begin
            logic [15:0] lo;
            lo = {s[3:0], s[3:0] ^ 4'h5, 6'(s * 3), 2'b01};
            send_long(lo, 16'h0000);
            send_long(lo, 16'h7FFF);
            send_long(lo, 16'h8000);
            send_long(lo, 16'hFFFF);
            send_long(lo, 16'h1234);
            send_long(lo, 16'hEDCB);
        end

        // R6/R7/R8: extended forms under back-pressure
        ready_mode = 1;
        for (int code = 0; code < 16; code++) begin
            for (int x = 0; x < 2; x++) begin
                for (int c = 0; c < 128; c++) begin
                    logic [15:0] lo;
                    logic [15:0] hi;
                    lo = {code[3:0], ~code[3:0], c[5:0], 2'b11};
                    hi = {code[3:0] + c[3:0], x[0], c[6:0], 4'(c + x)};
                    send_long(lo, hi);
                end
            end
        end
        for (int i = 0; i < 2048; i++) begin
            send_short({i[14:0] ^ 15'h2AAA, 1'b0});
        end
        ready_mode = 0;

        while (exp_q.size() != 0) idle(1);
        idle(3);
        chk(exp_q.size() == 0, "R4 all records delivered", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule